// File: doc/BRIEF.md
# Pulse-Width Fault Classifier

This block sits between a power stage's single fault line and the switching logic of an inverter controller. The power stage reports which fault happened by holding its fault line active for a length of time that depends on the fault type. The block passes the line through a synchroniser and counts how many clock cycles the active level lasts. When the line goes inactive, it compares the count against four programmable width windows. It then latches one of four fault flags, or an invalid-width flag when no window matches. Any completed pulse also raises an inhibit output that stops the switching logic.

The measuring part and the indicating part are separate modules. The window limits are plain inputs, so a different power stage needs only new limit values or a new classifier. A mode input selects between a disabled state and a run state. In the disabled state every output is held low and the fault line is ignored. In the run state, results stay latched until the mode input returns to disabled.

The measuring state machine has four states:
- OFF: held while the mode input is low.
- ARM: waits for the line to be inactive.
- IDLE: waits for the leading edge of a pulse.
- MEAS: counts the pulse.

Its transitions are:
- OFF→ARM when the block is enabled.
- ARM→IDLE when the line is low.
- IDLE→MEAS on a leading edge.
- MEAS→IDLE on a trailing edge. This transition emits a one-cycle done strobe carrying the measured width.
- Any state→OFF whenever the mode input is low.

Top module: `fault_width_decoder`

## Requirements
- R1: After `rst_n` is released with `run_en` low, `flag_o`, `invalid_o` and `inhibit_o` are all zero.
- R2: While `run_en` is low, all outputs are cleared within one clock and stay zero. A pulse on `fault_in` during this time leaves no result, neither while it lasts nor after the block is enabled again.
- R3: The width is the number of rising clock edges at which `fault_in` was sampled high. Class i (bit i of `flag_o`) matches when `win_min_i[i*CNT_W +: CNT_W]` ≤ width ≤ `win_max_i[i*CNT_W +: CNT_W]`, both limits inclusive. The bit assignment is: bit0 = output short circuit, bit1 = output overcurrent, bit2 = switch overtemperature, bit3 = supply undervoltage.
- R4: When several windows contain the width, only the lowest-numbered class is flagged.
- R5: A pulse whose width lies in no window sets `invalid_o` and sets no bit of `flag_o`.
- R6: The counter saturates at 2^CNT_W−1. A pulse that reaches this count is reported as invalid, even when a window covers that value.
- R7: Every completed pulse measured in run mode sets `inhibit_o`. `inhibit_o` is never high unless a flag or `invalid_o` is high.
- R8: Flags, `invalid_o` and `inhibit_o` remain set in run mode. A later pulse adds its own flag without clearing earlier ones.
- R9: A pulse that is already active when `run_en` rises is not measured.
- R10: Results appear at the fourth rising edge after the edge at which `fault_in` is first sampled low. At the third edge they are not yet visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | 1 = run mode, 0 = disabled/clear mode |
| fault_in | input | 1 | Asynchronous fault line, active high |
| win_min_i | input | 4*CNT_W | Per-class lower width limits, class i in slice i |
| win_max_i | input | 4*CNT_W | Per-class upper width limits, class i in slice i |
| flag_o | output | 4 | Latched per-class fault flags |
| invalid_o | output | 1 | Latched unmatched-width flag |
| inhibit_o | output | 1 | Latched switching inhibit |

## Verification
Faults in the counter or in the state machine show up as a wrong flag at the ports four cycles after the trailing edge. A count that is off by one shows up as a wrong class at each inclusive window limit, which is why the bench drives pulses at both ends of every window. A state machine that fails to arm correctly shows up as a spurious flag after a pulse that was already active at enable. Loss of latching shows up as a cleared flag after a second pulse. Saturation errors appear only for very long pulses, so one pulse longer than the counter range is driven against a window reaching the counter maximum.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int NCLASS = 4;

    typedef enum logic [1:0] {
        MS_OFF,
        MS_ARM,
        MS_IDLE,
        MS_MEAS
    } meas_state_t;
endpackage

// File: rtl/fwd_sync.sv
module fwd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/fwd_meter.sv
module fwd_meter
    import fwd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             line_s,
    output logic             done_o,
    output logic [CNT_W-1:0] width_o
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    meas_state_t state, nxt;
    logic [CNT_W-1:0] cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MS_OFF;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (!run_en) begin
            nxt = MS_OFF;
        end else begin
            unique case (state)
                MS_OFF:  nxt = MS_ARM;
                MS_ARM:  if (!line_s) nxt = MS_IDLE;
                MS_IDLE: if (line_s)  nxt = MS_MEAS;
                MS_MEAS: if (!line_s) nxt = MS_IDLE;
                default: nxt = MS_OFF;
            endcase
        end
    end

    // counter and done strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                MS_IDLE: if (line_s) cnt <= ONE;
                MS_MEAS: begin
                    if (!run_en)          cnt <= '0;
                    else if (line_s) begin
                        if (cnt != SAT)   cnt <= cnt + ONE;
                    end else              done_o <= 1'b1;
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign width_o = cnt;
endmodule

// File: rtl/fwd_classify.sv
module fwd_classify
    import fwd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0]        width_i,
    input  logic [NCLASS*CNT_W-1:0] win_min_i,
    input  logic [NCLASS*CNT_W-1:0] win_max_i,
    output logic [NCLASS-1:0]       hit_o,
    output logic                    invalid_o
);
    logic [NCLASS-1:0] raw;
    logic              sat;
    logic              taken;

    assign sat = &width_i;

    for (genvar g = 0; g < NCLASS; g++) begin : g_win
        assign raw[g] = (width_i >= win_min_i[g*CNT_W +: CNT_W]) &&
                        (width_i <= win_max_i[g*CNT_W +: CNT_W]);
    end

    // lowest class index wins on overlap
    always_comb begin
        hit_o = '0;
        taken = 1'b0;
        for (int i = 0; i < NCLASS; i++) begin
            if (raw[i] && !taken && !sat) begin
                hit_o[i] = 1'b1;
                taken    = 1'b1;
            end
        end
        invalid_o = !taken;
    end
endmodule

// File: rtl/fwd_latch.sv
module fwd_latch
    import fwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              done_i,
    input  logic [NCLASS-1:0] hit_i,
    input  logic              invalid_i,
    output logic [NCLASS-1:0] flag_o,
    output logic              invalid_o,
    output logic              inhibit_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o    <= '0;
            invalid_o <= 1'b0;
            inhibit_o <= 1'b0;
        end else if (!run_en) begin
            flag_o    <= '0;
            invalid_o <= 1'b0;
            inhibit_o <= 1'b0;
        end else if (done_i) begin
            flag_o    <= flag_o | hit_i;
            invalid_o <= invalid_o | invalid_i;
            inhibit_o <= 1'b1;
        end
    end
endmodule

// File: rtl/fault_width_decoder.sv
module fault_width_decoder
    import fwd_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_en,
    input  logic                    fault_in,
    input  logic [NCLASS*CNT_W-1:0] win_min_i,
    input  logic [NCLASS*CNT_W-1:0] win_max_i,
    output logic [NCLASS-1:0]       flag_o,
    output logic                    invalid_o,
    output logic                    inhibit_o
);
    logic              line_s;
    logic              done;
    logic [CNT_W-1:0]  width;
    logic [NCLASS-1:0] hit;
    logic              unmatched;

    fwd_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(fault_in), .q(line_s)
    );

    fwd_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .line_s(line_s),
        .done_o(done), .width_o(width)
    );

    fwd_classify #(.CNT_W(CNT_W)) u_cls (
        .width_i(width), .win_min_i(win_min_i), .win_max_i(win_max_i),
        .hit_o(hit), .invalid_o(unmatched)
    );

    fwd_latch u_ind (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .done_i(done),
        .hit_i(hit), .invalid_i(unmatched),
        .flag_o(flag_o), .invalid_o(invalid_o), .inhibit_o(inhibit_o)
    );
endmodule

// File: rtl/fault_width_decoder_chk.sv
module fault_width_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run_en,
    input logic       fault_in,
    input logic [3:0] flag_o,
    input logic       invalid_o,
    input logic       inhibit_o
);
    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (flag_o == 4'b0 && !invalid_o && !inhibit_o));

    assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run_en) |-> ((flag_o & $past(flag_o)) == $past(flag_o)));

    assert_inhibit_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_o == ((|flag_o) || invalid_o)));

    assert_single_new_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flag_o & ~$past(flag_o)) <= 1);

    assert_result_after_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(flag_o & ~$past(flag_o))) || $rose(invalid_o)) |-> !$past(fault_in, 3));
endmodule

bind fault_width_decoder fault_width_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .fault_in(fault_in),
    .flag_o(flag_o), .invalid_o(invalid_o), .inhibit_o(inhibit_o)
);

// File: tb/sim_fault_width_decoder.sv
module sim_fault_width_decoder;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_en = 1'b0;
    logic         fault_in = 1'b0;
    logic [4*W-1:0] win_min, win_max;
    logic [3:0]   flag_o;
    logic         invalid_o, inhibit_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fault_width_decoder #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .fault_in(fault_in),
        .win_min_i(win_min), .win_max_i(win_max),
        .flag_o(flag_o), .invalid_o(invalid_o), .inhibit_o(inhibit_o)
    );

    // width, expected {invalid, flags}
    localparam int         NV = 12;
    localparam int         VW[NV] = '{2, 4, 3, 5, 6, 9, 12, 16, 20, 30, 31, 1};
    localparam logic [4:0] VE[NV] = '{5'b00001, 5'b00001, 5'b00001, 5'b10000,
                                      5'b00010, 5'b00010, 5'b00100, 5'b00100,
                                      5'b01000, 5'b01000, 5'b10000, 5'b10000};

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got {inh,inv,flags}=%b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {inhibit_o, invalid_o, flag_o};
    endfunction

    task automatic set_windows();
        win_min = {8'd20, 8'd12, 8'd6, 8'd2};
        win_max = {8'd30, 8'd16, 8'd9, 8'd4};
    endtask

    task automatic rearm();
        @(negedge clk) run_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 clear", outs(), 6'b0);
        run_en = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(input int n);
        @(negedge clk) fault_in = 1'b1;
        repeat (n) @(negedge clk);
        fault_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        set_windows();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", outs(), 6'b0);

        // table walk: R3 R5 R7 at window edges
        for (int i = 0; i < NV; i++) begin
            rearm();
            pulse(VW[i]);
            check("R3/R5/R7 vector", outs(), {1'b1, VE[i]});
        end

        // R2: pulse while disabled is ignored
        @(negedge clk) run_en = 1'b0;
        pulse(3);
        check("R2 disabled pulse", outs(), 6'b0);
        run_en = 1'b1;
        repeat (6) @(negedge clk);
        check("R2 after enable", outs(), 6'b0);

        // R9: pulse active at enable is not measured
        @(negedge clk) run_en = 1'b0;
        repeat (2) @(negedge clk);
        fault_in = 1'b1;
        repeat (3) @(negedge clk);
        run_en = 1'b1;
        repeat (5) @(negedge clk);
        fault_in = 1'b0;
        repeat (6) @(negedge clk);
        check("R9 pre-active pulse", outs(), 6'b0);

        // R8: latching and accumulation
        rearm();
        pulse(3);
        check("R8 first", outs(), 6'b100001);
        pulse(6);
        check("R8 accumulate", outs(), 6'b100011);
        repeat (10) @(negedge clk);
        check("R8 held", outs(), 6'b100011);

        // R4: overlap priority
        win_min[1*W +: W] = 8'd3;
        rearm();
        pulse(3);
        check("R4 overlap low class", outs(), 6'b100001);
        pulse(5);
        check("R4 only class1", outs(), 6'b100011);
        set_windows();

        // R6: saturation
        win_max[3*W +: W] = 8'd255;
        rearm();
        pulse(254);
        check("R6 below sat", outs(), 6'b101000);
        rearm();
        pulse(300);
        check("R6 saturated", outs(), 6'b110000);
        set_windows();

        // R10: latency
        rearm();
        @(negedge clk) fault_in = 1'b1;
        repeat (3) @(negedge clk);
        fault_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 third edge", outs(), 6'b0);
        @(negedge clk);
        check("R10 fourth edge", outs(), 6'b100001);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule